// File: doc/BRIEF.md
# Registered Manchester Line Encoder

This block serialises bytes onto a single wire using Manchester coding. Each data bit becomes two half-bit symbols with a level change in the middle of the bit, so the receiver can take its timing from the line itself and the line never sits at one level for long. Bytes arrive on a valid/ready handshake and leave most significant bit first. An internal divider turns the system clock into a one-cycle half-bit enable whose period is set by a `divisor` input.

The line level is always taken from a flip-flop that is loaded with the next half-bit symbol. It is never formed by gating a bit clock with the data, so a skew between two signals cannot put a spurious edge on the wire. When nothing is pending, the line rests low and `busy` is low. A byte offered during the last half-bit of the byte in flight is taken at once, so a stream of bytes goes out without a gap. A polarity input selects the opposite symbol convention. Its value is captured when a byte is accepted.

Top module: `mcode_line_encoder`

## Requirements
- R1: With polarity 0, a data bit of 1 is sent as a high half-bit followed by a low half-bit.
- R2: With polarity 0, a data bit of 0 is sent as a low half-bit followed by a high half-bit.
- R3: Bits leave MSB first (bit 7 first). Each half-bit lasts exactly `divisor`+1 clock cycles. The first half of bit 7 appears on `lineOut` in the cycle after the accepting clock edge.
- R4: While no byte is in flight, `lineOut` is 0, `busy` is 0 and `inReady` is 1.
- R5: A byte offered while idle is accepted at the next clock edge (`inValid` and `inReady` both 1), and `busy` is 1 from the next cycle on.
- R6: While a byte is in flight, `inReady` is 1 only in the last clock cycle of its final half-bit. A byte accepted there starts in the following cycle, with no idle gap.
- R7: `inValid` and `inData` presented while `inReady` is 0 have no effect on the bits sent.
- R8: With `invertPol` = 1, the symbol convention is reversed (a 1 is sent low then high). The value of `invertPol` is captured with each byte at acceptance, and later changes do not affect that byte.
- R9: While `busy` is 1, `lineOut` never stays at one level for more than 2·(`divisor`+1) consecutive cycles.
- R10: During and after reset, `lineOut` = 0, `busy` = 0 and `inReady` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divisor | input | DIV_W | Half-bit length minus one, in clock cycles; change only while idle |
| invertPol | input | 1 | 1 selects the reversed symbol convention; captured per byte |
| inData | input | DATA_W | Byte to send |
| inValid | input | 1 | `inData` is offered |
| inReady | output | 1 | Encoder takes the offered byte at this edge |
| lineOut | output | 1 | Registered Manchester line |
| busy | output | 1 | A byte is being sent |

## Verification
The bound checker enforces the following on every cycle:
- the line rests low and ready is high whenever the encoder is idle;
- an accepted byte always makes the block busy;
- no constant run on the line exceeds two half-bit lengths.

The bench is needed for the exact symbol sequence: bit order, half-bit length for several divisors, polarity capture against mid-byte changes, and back-to-back streaming with no gap. It also shows that offers made while `inReady` is low are ignored. These can only be seen by comparing the line against a model over whole scenarios.

// File: rtl/mcode_pkg.sv
package mcode_pkg;
  // Strobes from the sequencer to the symbol datapath
  typedef struct packed {
    logic loadByte;    // capture a new byte, drive first half of its MSB
    logic secondHalf;  // switch to second half of the current bit
    logic nextBit;     // shift and drive first half of the next bit
    logic goIdle;      // byte finished with nothing pending
  } mcodeStrobes_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_SEND = 1'b1} mcodeState_e;
endpackage

// File: rtl/mcode_half_tick.sv
module mcode_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             halfTick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      cnt <= '0;
    end else if (cnt == divisor) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign halfTick = run && (cnt == divisor);
endmodule

// File: rtl/mcode_ctrl.sv
module mcode_ctrl
  import mcode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          halfTick,
  input  logic          inValid,
  output logic          inReady,
  output logic          busy,
  output mcodeStrobes_t strobes
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(DATA_W - 1);

  mcodeState_e state;
  logic        halfSel;
  logic [CW-1:0] bitCnt;
  logic        finalTick;
  logic        accept;

  assign finalTick = (state == ST_SEND) && halfTick && halfSel && (bitCnt == '0);
  assign inReady   = (state == ST_IDLE) || finalTick;
  assign accept    = inReady && inValid;
  assign busy      = (state == ST_SEND);

  always_comb begin
    strobes            = '0;
    strobes.loadByte   = accept;
    strobes.secondHalf = (state == ST_SEND) && halfTick && !halfSel;
    strobes.nextBit    = (state == ST_SEND) && halfTick && halfSel && (bitCnt != '0);
    strobes.goIdle     = finalTick && !inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfSel <= 1'b0;
      bitCnt  <= '0;
    end else begin
      if (strobes.loadByte) begin
        state   <= ST_SEND;
        halfSel <= 1'b0;
        bitCnt  <= LAST_IDX;
      end else if (strobes.goIdle) begin
        state   <= ST_IDLE;
        halfSel <= 1'b0;
      end else if (strobes.secondHalf) begin
        halfSel <= 1'b1;
      end else if (strobes.nextBit) begin
        halfSel <= 1'b0;
        bitCnt  <= bitCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mcode_datapath.sv
module mcode_datapath
  import mcode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mcodeStrobes_t     strobes,
  input  logic [DATA_W-1:0] inData,
  input  logic              invertPol,
  output logic              lineOut
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] shiftReg;
  logic              polReg;
  logic              lineReg;
  logic              followBit;

  generate
    if (DATA_W > 1) begin : g_wide
      assign followBit = shiftReg[MSB-1];
    end else begin : g_single
      assign followBit = shiftReg[0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      polReg   <= 1'b0;
      lineReg  <= 1'b0;
    end else if (strobes.loadByte) begin
      shiftReg <= inData;
      polReg   <= invertPol;
      lineReg  <= inData[MSB] ^ invertPol;
    end else if (strobes.goIdle) begin
      lineReg  <= 1'b0;
    end else if (strobes.secondHalf) begin
      lineReg  <= ~shiftReg[MSB] ^ polReg;
    end else if (strobes.nextBit) begin
      shiftReg <= shiftReg << 1;
      lineReg  <= followBit ^ polReg;
    end
  end

  assign lineOut = lineReg;
endmodule

// File: rtl/mcode_line_encoder.sv
module mcode_line_encoder
  import mcode_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              invertPol,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              lineOut,
  output logic              busy
);
  mcodeStrobes_t strobes;
  logic          halfTick;

  mcode_half_tick #(.DIV_W(DIV_W)) uTick (
    .clk(clk), .rstN(rstN), .run(busy), .divisor(divisor), .halfTick(halfTick)
  );

  mcode_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .inValid(inValid),
    .inReady(inReady), .busy(busy), .strobes(strobes)
  );

  mcode_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inData(inData),
    .invertPol(invertPol), .lineOut(lineOut)
  );
endmodule

// File: rtl/mcode_line_checker.sv
module mcode_line_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [DIV_W-1:0] divisor,
  input logic             inValid,
  input logic             inReady,
  input logic             lineOut,
  input logic             busy
);
  localparam int RW = DIV_W + 3;

  logic [RW-1:0] runLen;
  logic          prevLine;
  logic [RW-1:0] runLimit;

  assign runLimit = {2'b00, divisor, 1'b0} + RW'(2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLen   <= '0;
      prevLine <= 1'b0;
    end else begin
      prevLine <= lineOut;
      if (!busy) runLen <= '0;
      else if (lineOut != prevLine || runLen == '0) runLen <= RW'(1);
      else if (runLen != '1) runLen <= runLen + 1'b1;
    end
  end

  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !lineOut); // R4
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> inReady); // R4
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> busy); // R5
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (runLen <= runLimit)); // R9
endmodule

bind mcode_line_encoder mcode_line_checker #(.DIV_W(DIV_W)) uChk (
  .clk(clk), .rstN(rstN), .divisor(divisor), .inValid(inValid),
  .inReady(inReady), .lineOut(lineOut), .busy(busy)
);

// File: tb/tb_mcode_line_encoder.sv
module tb_mcode_line_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DIV_W-1:0] divisor = '0;
  logic invertPol = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic inValid = 1'b0;
  logic inReady, lineOut, busy;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  bit done = 0;

  mcode_line_encoder #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut (
    .clk(clk), .rstN(rstN), .divisor(divisor), .invertPol(invertPol),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .lineOut(lineOut), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic expSym(input logic [7:0] b, input logic pol, input int h);
    logic bitV;
    bitV = b[7 - h/2];
    return (((h % 2) == 0) ? bitV : ~bitV) ^ pol;
  endfunction

  // Send n bytes back to back; pressure drives junk offers while not ready
  task automatic sendStream(input logic [7:0] b [4], input int n, input int d,
                            input logic [3:0] pols, input bit pressure);
    int runLen;
    logic lastLine;
    @(negedge clk);
    inValid = 1'b0;
    divisor = DIV_W'(d);
    @(negedge clk);
    check(lineOut == 1'b0, "R4 idle line", int'(lineOut), 0);
    check(busy == 1'b0, "R4 idle busy", int'(busy), 0);
    check(inReady == 1'b1, "R4 idle ready", int'(inReady), 1);
    inData = b[0];
    invertPol = pols[0];
    inValid = 1'b1;
    check(inReady == 1'b1, "R5 ready on offer", int'(inReady), 1);
    runLen = 0;
    lastLine = 1'b0;
    for (int k = 0; k < n; k++) begin
      for (int h = 0; h < 16; h++) begin
        for (int c = 0; c <= d; c++) begin
          logic e;
          string tag;
          @(negedge clk);
          e = expSym(b[k], pols[k], h);
          tag = pols[k] ? "R8 R3 symbol" : (b[k][7 - h/2] ? "R1 R3 symbol" : "R2 R3 symbol");
          check(lineOut == e, tag, int'(lineOut), int'(e));
          check(busy == 1'b1, "R5 busy", int'(busy), 1);
          if (lineOut == lastLine && !(k == 0 && h == 0 && c == 0)) runLen++;
          else runLen = 1;
          lastLine = lineOut;
          check(runLen <= 2*(d+1), "R9 run length", runLen, 2*(d+1));
          if (h == 15 && c == d) begin
            check(inReady == 1'b1, "R6 ready at final tick", int'(inReady), 1);
            if (k + 1 < n) begin
              inData = b[k+1];
              invertPol = pols[k+1];
              inValid = 1'b1;
            end else begin
              inValid = 1'b0;
              invertPol = 1'(($urandom));
            end
          end else begin
            if (h == 0 && c == 0) begin
              inValid = 1'b0;
            end else begin
              check(inReady == 1'b0, "R6 R7 not ready mid byte", int'(inReady), 0);
              if (pressure) begin
                inValid = 1'b1;
                inData = 8'($urandom);
                invertPol = 1'($urandom);
              end else begin
                inValid = 1'b0;
              end
            end
          end
        end
      end
    end
    @(negedge clk);
    check(lineOut == 1'b0, "R4 line after stream", int'(lineOut), 0);
    check(busy == 1'b0, "R4 busy after stream", int'(busy), 0);
    check(inReady == 1'b1, "R4 ready after stream", int'(inReady), 1);
  endtask

  initial begin
    logic [7:0] bs [4];
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    check(lineOut == 1'b0, "R10 reset line", int'(lineOut), 0);
    check(busy == 1'b0, "R10 reset busy", int'(busy), 0);
    check(inReady == 1'b1, "R10 reset ready", int'(inReady), 1);
    rstN = 1'b1;

    bs = '{8'hFF, 8'h00, 8'h00, 8'h00};
    sendStream(bs, 1, 0, 4'b0000, 1'b0);   // R1 all ones
    bs = '{8'h00, 8'h00, 8'h00, 8'h00};
    sendStream(bs, 1, 0, 4'b0000, 1'b0);   // R2 all zeros
    bs = '{8'hA5, 8'h00, 8'h00, 8'h00};
    sendStream(bs, 1, 3, 4'b0000, 1'b1);   // R3 R7 longer halves with pressure
    bs = '{8'h3C, 8'hC3, 8'h81, 8'h7E};
    sendStream(bs, 4, 2, 4'b0110, 1'b1);   // R6 R8 back to back, mixed polarity
    bs = '{8'h01, 8'h80, 8'h00, 8'h00};
    sendStream(bs, 2, 1, 4'b1111, 1'b0);   // R8 inverted stream

    for (int i = 0; i < 25; i++) begin
      int n;
      for (int j = 0; j < 4; j++) bs[j] = 8'($urandom);
      n = 1 + int'($urandom % 4);
      sendStream(bs, n, int'($urandom % 5), 4'($urandom), 1'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule